// File: doc/BRIEF.md
# Eight-Way Chip-Select Address Decoder

This block turns a 32-bit bus address into one of eight chip selects for an external memory bus. Each bank owns one configuration word. The word holds a region base aligned to 128 KiB, a per-bit compare enable for address bits 31:17, and an enable flag. Regions are powers of two in size and aligned to their own size, so a region is described fully by which upper address bits must equal the base. Each bank also owns five timing words. They are plain storage for a timing engine that sits outside this block.

Addresses arrive on a valid/ready input stream. Each accepted address produces one result beat on a valid/ready output stream. The beat carries a one-hot chip-select vector and a hit flag. The output stage is one register deep:
- The input is ready whenever the output register is empty or is being drained in the same cycle.
- While the output is valid and not taken, the input is held off and the result stays frozen.

Banks 0 and 1 have a special case. If either configuration word is all zeros, that bank claims every address, even with its enable flag clear. Software parks an unused low bank by writing all ones instead. A boot-swap strap is sampled while reset is held. When it is set, chip selects 0 and 1 trade places.

Top module: `csd_top`

## Requirements
- R1: During reset the strap `boot_swap` is captured. After reset, bank 0's configuration word reads 0x00000001 if the strap was low and 0x00000000 if it was high. Every other configuration word and every timing word reads zero, and `out_valid` is low.
- R2: Register word offsets are laid out as follows, and a write followed by a read returns the written value:
  - Bank n's configuration word is at 0x40+4n.
  - Bank n's timing words are at 0x80+4n+k for k = 0..3, and at 0xC0+4n.
  - Read data appears on `reg_rdata` in the cycle after `reg_re`.
- R3: A write to any other word offset changes nothing, and a read from such an offset returns zero.
- R4: A bank matches an address when both hold:
  - Configuration bit 0 (enable) is set.
  - For every i in 0..14 where configuration bit 1+i is set, address bit 17+i equals configuration bit 17+i.

  An address accepted on the input yields its result on the next clock edge.
- R5: A bank whose enable bit is clear never matches, unless R6 applies. A zero configuration word in banks 2 to 7 matches nothing.
- R6: A configuration word of exactly zero in bank 0 or bank 1 makes that bank match every address.
- R7: When several banks match, only the lowest-numbered one drives its chip select, so `out_cs` is one-hot or zero.
- R8: An address that no bank matches gives `out_hit` = 0 and `out_cs` = 0.
- R9: With the strap captured high, a win by bank 0 drives `out_cs[1]` and a win by bank 1 drives `out_cs[0]`.
- R10: `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_cs` and `out_hit` hold.
- R11: If a configuration write and an address acceptance fall in the same cycle, the address is decoded with the configuration as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_swap | input | 1 | Swap strap, captured while reset is low |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_re` |
| in_valid | input | 1 | Address beat valid |
| in_ready | output | 1 | Address beat accepted when high with `in_valid` |
| in_addr | input | 32 | Bus address to decode |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream takes the result |
| out_cs | output | 8 | One-hot chip-select vector |
| out_hit | output | 1 | Some bank matched |

## Verification
A configuration write and an address decode can land on the same clock edge.

The bench raises a write that retargets bank 2 in the same cycle as an address that lies in bank 2's old region. It expects the old chip select to come back, which shows the decode used the configuration from before the edge. It then sends two more addresses to confirm that the new region took effect and the old one no longer matches.

Back-pressure is provoked by holding `out_ready` low across several cycles with a second address waiting. The bench checks that the frozen result and the handover on release are both correct.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int WORD_W        = 32;
  localparam int REGION_LSB    = 17;
  localparam int CMP_BITS      = WORD_W - REGION_LSB;
  localparam int TIMING_WORDS  = 5;
  localparam int CATCHALL_LOW  = 2;
  localparam int CFG_WORD0     = 'h40;
  localparam int TIM_WORD0     = 'h80;
  localparam int TIM_EXTRA0    = 'hC0;
  localparam int BANK_STRIDE   = 4;

  function automatic int cfg_word(input int bank);
    return CFG_WORD0 + BANK_STRIDE * bank;
  endfunction

  function automatic int tim_word(input int bank, input int idx);
    if (idx < TIMING_WORDS - 1)
      return TIM_WORD0 + BANK_STRIDE * bank + idx;
    else
      return TIM_EXTRA0 + BANK_STRIDE * bank;
  endfunction
endpackage

// File: rtl/csd_regfile.sv
module csd_regfile
  import csd_pkg::*;
#(
  parameter int NB = 8,
  parameter int AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     boot_swap,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata,
  output logic                     swap_q,
  output logic [NB-1:0][WORD_W-1:0] cfg_q
);
  logic [NB-1:0][TIMING_WORDS-1:0][WORD_W-1:0] tim_q;
  logic [WORD_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (!rst_n) swap_q <= boot_swap;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [AW-1:0] CFG_OFS = AW'(cfg_word(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        if (b == 0) cfg_q[b] <= {{(WORD_W-1){1'b0}}, ~boot_swap};
        else        cfg_q[b] <= '0;
      end else if (wr_en && addr == CFG_OFS) begin
        cfg_q[b] <= wdata;
      end
    end
    for (genvar t = 0; t < TIMING_WORDS; t++) begin : g_tim
      localparam logic [AW-1:0] TIM_OFS = AW'(tim_word(b, t));
      always_ff @(posedge clk) begin
        if (!rst_n)                        tim_q[b][t] <= '0;
        else if (wr_en && addr == TIM_OFS) tim_q[b][t] <= wdata;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr == AW'(cfg_word(b))) rd_next = cfg_q[b];
      for (int t = 0; t < TIMING_WORDS; t++) begin
        if (addr == AW'(tim_word(b, t))) rd_next = tim_q[b][t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/csd_bank_match.sv
module csd_bank_match
  import csd_pkg::*;
#(
  parameter int BANK = 0
) (
  input  logic [WORD_W-1:0] cfg,
  input  logic [WORD_W-1:0] addr,
  output logic              match
);
  logic [CMP_BITS-1:0] diff;
  logic                normal;
  logic                unused_gap;

  assign unused_gap = cfg[REGION_LSB-1];
  assign diff   = (addr[WORD_W-1:REGION_LSB] ^ cfg[WORD_W-1:REGION_LSB])
                  & cfg[CMP_BITS:1];
  assign normal = cfg[0] && (diff == '0);

  if (BANK < CATCHALL_LOW) begin : g_catch
    assign match = normal || (cfg == '0);
  end else begin : g_plain
    assign match = normal;
  end
endmodule

// File: rtl/csd_pick.sv
module csd_pick #(
  parameter int NB = 8
) (
  input  logic [NB-1:0] match,
  input  logic          swap,
  output logic [NB-1:0] cs,
  output logic          hit
);
  logic [NB-1:0] win;
  logic          found;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (match[i] && !found) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    cs = win;
    if (swap) begin
      cs[0] = win[1];
      cs[1] = win[0];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/csd_top.sv
module csd_top
  import csd_pkg::*;
#(
  parameter int NB = 8,
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_swap,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NB-1:0]     out_cs,
  output logic              out_hit
);
  logic [NB-1:0][WORD_W-1:0] cfg_q;
  logic                      swap_q;
  logic [NB-1:0]             match;
  logic [NB-1:0]             cs_d;
  logic                      hit_d;

  csd_regfile #(.NB(NB), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .boot_swap(boot_swap),
    .wr_en(reg_we), .rd_en(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .swap_q(swap_q), .cfg_q(cfg_q)
  );

  for (genvar b = 0; b < NB; b++) begin : g_match
    csd_bank_match #(.BANK(b)) u_match (
      .cfg(cfg_q[b]), .addr(in_addr), .match(match[b])
    );
  end

  csd_pick #(.NB(NB)) u_pick (
    .match(match), .swap(swap_q), .cs(cs_d), .hit(hit_d)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cs    <= '0;
      out_hit   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cs  <= cs_d;
        out_hit <= hit_d;
      end
    end
  end
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [NB-1:0] out_cs,
  input logic          out_hit
);
  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_cs));

  p_hit_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit == (out_cs != '0)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cs) && $stable(out_hit)));

  p_empty_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind csd_top csd_checker #(.NB(NB)) u_csd_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_cs(out_cs),
  .out_hit(out_hit)
);

// File: tb/tb_csd_top.sv
module tb_csd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_swap = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_cs;
  logic        out_hit;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  csd_top dut (
    .clk(clk), .rst_n(rst_n), .boot_swap(boot_swap),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_cs(out_cs), .out_hit(out_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; boot_swap = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; boot_swap = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic decode(input string req, input logic [31:0] a,
                        input logic [7:0] exp_cs, input logic exp_hit);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {31'b0, out_valid}, 32'd1);
    chk(req, {24'b0, out_cs}, {24'b0, exp_cs});
    chk(req, {31'b0, out_hit}, {31'b0, exp_hit});
  endtask

  task automatic t_reset_values();
    logic [31:0] v;
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    rd(8'h40, v); chk("R1 bank0 cfg", v, 32'h1);
    rd(8'h44, v); chk("R1 bank1 cfg", v, 32'h0);
    rd(8'h54, v); chk("R1 bank5 cfg", v, 32'h0);
    rd(8'h80, v); chk("R1 timing", v, 32'h0);
    rd(8'hC4, v); chk("R1 timing extra", v, 32'h0);
    decode("R7 reset bank0 over bank1", 32'h1234_5678, 8'h01, 1'b1);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(8'h48, 32'h2000_FFFF); rd(8'h48, v); chk("R2 bank2 cfg", v, 32'h2000_FFFF);
    wr(8'h85, 32'hA5A5_5A5A); rd(8'h85, v); chk("R2 bank1 timing1", v, 32'hA5A5_5A5A);
    wr(8'hDC, 32'h0BAD_F00D); rd(8'hDC, v); chk("R2 bank7 timing extra", v, 32'h0BAD_F00D);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h41, 32'hDEAD_BEEF); rd(8'h41, v); chk("R3 gap read", v, 32'h0);
    wr(8'hC1, 32'h1111_2222); rd(8'hC1, v); chk("R3 gap read 2", v, 32'h0);
    rd(8'h40, v); chk("R3 neighbour intact", v, 32'hFFFF_FFFF);
    decode("R3 decode intact", 32'h2001_0000, 8'h04, 1'b1);
  endtask

  task automatic t_match();
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h4C, 32'h4000_FFF1);
    decode("R4 bank2 hit", 32'h2001_0004, 8'h04, 1'b1);
    decode("R8 miss above bank2", 32'h2002_0000, 8'h00, 1'b0);
    decode("R4 bank3 1MiB", 32'h400A_BCDE, 8'h08, 1'b1);
    decode("R7 parked top both", 32'hFFFF_0000, 8'h01, 1'b1);
    decode("R8 miss low", 32'h1234_5678, 8'h00, 1'b0);
  endtask

  task automatic t_disable_and_priority();
    wr(8'h50, 32'h6000_FFF0);
    decode("R5 disabled bank4", 32'h6000_0000, 8'h00, 1'b0);
    wr(8'h50, 32'h4000_FFFF);
    decode("R7 bank3 over bank4", 32'h4000_0000, 8'h08, 1'b1);
  endtask

  task automatic t_catchall();
    wr(8'h44, 32'h0);
    decode("R6 bank1 zero catches", 32'h1234_5678, 8'h02, 1'b1);
    decode("R6 bank1 over bank2", 32'h2001_0000, 8'h02, 1'b1);
    wr(8'h40, 32'h0);
    decode("R6 bank0 zero catches", 32'h2001_0000, 8'h01, 1'b1);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
  endtask

  task automatic t_stall();
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h2001_0000;
    @(negedge clk);
    in_addr = 32'h400A_0000;
    chk("R10 ready low when full", {31'b0, in_ready}, 32'd0);
    chk("R10 first result", {24'b0, out_cs}, 32'h04);
    @(negedge clk);
    chk("R10 held valid", {31'b0, out_valid}, 32'd1);
    chk("R10 held cs", {24'b0, out_cs}, 32'h04);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 handover cs", {24'b0, out_cs}, 32'h08);
    chk("R10 handover valid", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R10 drained", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h48; reg_wdata = 32'h5000_FFFF;
    in_valid = 1'b1; in_addr = 32'h2001_0000;
    @(negedge clk);
    reg_we = 1'b0; in_valid = 1'b0;
    chk("R11 old config used", {24'b0, out_cs}, 32'h04);
    decode("R11 old region gone", 32'h2001_0000, 8'h00, 1'b0);
    decode("R11 new region live", 32'h5000_0000, 8'h04, 1'b1);
  endtask

  task automatic t_swap();
    logic [31:0] v;
    do_reset(1'b1);
    rd(8'h40, v); chk("R1 swapped bank0 cfg", v, 32'h0);
    decode("R9 bank0 catch to cs1", 32'h1234_0000, 8'h02, 1'b1);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'h2000_FFFF);
    decode("R9 bank1 to cs0", 32'h2000_0000, 8'h01, 1'b1);
    decode("R9 bank0 to cs1", 32'hFFFE_0000, 8'h02, 1'b1);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset_values();
    t_regmap();
    t_match();
    t_unmapped();
    t_disable_and_priority();
    t_catchall();
    t_stall();
    t_same_cycle();
    t_swap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule